// File: doc/BRIEF.md
# Call, Restart and Absolute-Store Write Sequencer

This unit is a small multi-cycle controller inside a processor core. It carries out subroutine calls, fixed-vector restarts and stores of a register value to an absolute address. These operations share one datapath that emits one or two byte writes on a memory write port.

A call first lowers the stack pointer by two. It then writes the return address, low byte first, at the new stack pointer and the byte above it, and loads the program counter with the call target. A restart does the same, but its target comes from one of eight fixed vectors in low memory. A store writes a register value at an absolute address, as two bytes or one, and advances the program counter past the three-byte instruction. The stack pointer is left unchanged by a store.

The core pulses the start input with all operands valid. It waits for the one-cycle done pulse, then takes the updated program counter and stack pointer from the outputs.

Top module: `stk_push_seq`

## Requirements
- R1: After reset the unit is idle: no write strobe, busy and done low, and the program counter and stack pointer outputs are zero.
- R2: A call (op code 0) or restart (op code 1) returns a stack pointer equal to the start stack pointer minus 2, modulo 2^16.
- R3: A call or restart performs exactly two writes. The first writes the low byte of the return address at stack pointer minus 2. The second writes the high byte at the next address, with 16-bit wrap.
- R4: A call returns a program counter equal to the 16-bit target presented at start.
- R5: A restart returns a program counter equal to the 3-bit vector index times 8, zero-extended to 16 bits. The target input is ignored.
- R6: A wide store (op code 2) writes the low byte of the data input at the target address and then its high byte at target plus 1, with wrap. It returns the program counter plus 3 and the stack pointer unchanged.
- R7: A narrow store (op code 3) performs a single write of the data input's low byte at the target address. It returns the program counter plus 3 and the stack pointer unchanged.
- R8: Each write holds its strobe, address and data steady until the cycle in which ready is high. That cycle completes the write. No write is strobed while the unit is idle.
- R9: Done is high for exactly one cycle, the cycle after the final write is accepted. The program counter and stack pointer outputs change only in that cycle. Busy is low in the cycle after done.
- R10: A start pulse while the unit is busy is ignored. It causes no extra write and does not change the results.
- R11: The return address, target, stack pointer and data are taken from the inputs in the start cycle. Later changes on those inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, operands valid in the same cycle |
| op_i | input | 2 | 0 call, 1 restart, 2 wide store, 3 narrow store |
| vec_i | input | 3 | Restart vector index |
| tgt_i | input | 16 | Call target or store address |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 16 | Current stack pointer |
| data_i | input | 16 | Register value for stores |
| mem_we_o | output | 1 | Byte write strobe |
| mem_addr_o | output | 16 | Write address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdy_i | input | 1 | Write accepted when high with strobe |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pc_o | output | 16 | Updated program counter |
| sp_o | output | 16 | Updated stack pointer |

## Verification
The first write strobe appears one cycle after the start edge. Each write is complete at the first edge where ready is high. With ready always high, done therefore follows start by three cycles for two-write operations and by two for the narrow store. The program counter and stack pointer outputs are valid in the done cycle. The bench samples on the falling edge and decides ready in the same half-cycle. It does not assume fixed latencies: it counts each accepted write and requires done exactly one cycle after the last one, even when ready is withheld for several cycles before either write.

// File: rtl/stk_push_pkg.sv
package stk_push_pkg;
  typedef enum logic [1:0] {OP_CALL = 2'd0, OP_RST = 2'd1, OP_ST16 = 2'd2, OP_ST8 = 2'd3} op_e;
  typedef enum logic [1:0] {S_IDLE, S_WR0, S_WR1, S_DONE} st_e;
endpackage

// File: rtl/stk_push_frame.sv
module stk_push_frame
  import stk_push_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int VEC_W      = 3,
  parameter int VEC_STRIDE = 8,
  parameter int PC_ADV     = 3
) (
  input  op_e               op_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] word_o,
  output logic              two_o,
  output logic [ADDR_W-1:0] pc_nxt_o,
  output logic [ADDR_W-1:0] sp_nxt_o
);
  localparam logic [ADDR_W-1:0] FRAME = ADDR_W'(2);
  logic [ADDR_W-1:0] vec_addr, sp_dec;

  assign vec_addr = ADDR_W'(vec_i) * ADDR_W'(VEC_STRIDE);
  assign sp_dec   = sp_i - FRAME;

  always_comb begin
    base_o   = tgt_i;
    word_o   = data_i;
    two_o    = 1'b1;
    pc_nxt_o = pc_i + ADDR_W'(PC_ADV);
    sp_nxt_o = sp_i;
    unique case (op_i)
      OP_CALL, OP_RST: begin
        base_o   = sp_dec;
        word_o   = pc_i;
        sp_nxt_o = sp_dec;
        pc_nxt_o = (op_i == OP_RST) ? vec_addr : tgt_i;
      end
      OP_ST8:  two_o = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/stk_push_fsm.sv
module stk_push_fsm
  import stk_push_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic two_i,
  input  logic rdy_i,
  output logic load_o,
  output logic fin_o,
  output logic we_o,
  output logic hi_o,
  output logic busy_o,
  output logic done_o
);
  st_e st_q, st_d;

  always_comb begin
    st_d   = st_q;
    load_o = 1'b0;
    fin_o  = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin st_d = S_WR0; load_o = 1'b1; end
      S_WR0: if (rdy_i) begin
        st_d  = two_i ? S_WR1 : S_DONE;
        fin_o = !two_i;
      end
      S_WR1: if (rdy_i) begin st_d = S_DONE; fin_o = 1'b1; end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;

  assign we_o   = (st_q == S_WR0) || (st_q == S_WR1);
  assign hi_o   = (st_q == S_WR1);
  assign busy_o = (st_q != S_IDLE);
  assign done_o = (st_q == S_DONE);
endmodule

// File: rtl/stk_push_seq.sv
module stk_push_seq
  import stk_push_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int VEC_W      = 3,
  parameter int VEC_STRIDE = 8,
  parameter int PC_ADV     = 3,
  localparam int BYTE_W    = ADDR_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic              mem_rdy_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o
);
  logic [ADDR_W-1:0] base_c, word_c, pcn_c, spn_c;
  logic [ADDR_W-1:0] base_q, word_q, pcn_q, spn_q;
  logic              two_c, two_q, load, fin, hi;

  stk_push_frame #(
    .ADDR_W(ADDR_W), .VEC_W(VEC_W), .VEC_STRIDE(VEC_STRIDE), .PC_ADV(PC_ADV)
  ) u_frame (
    .op_i(op_e'(op_i)), .vec_i(vec_i), .tgt_i(tgt_i), .pc_i(pc_i), .sp_i(sp_i),
    .data_i(data_i), .base_o(base_c), .word_o(word_c), .two_o(two_c),
    .pc_nxt_o(pcn_c), .sp_nxt_o(spn_c)
  );

  stk_push_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .two_i(two_q),
    .rdy_i(mem_rdy_i), .load_o(load), .fin_o(fin), .we_o(mem_we_o), .hi_o(hi),
    .busy_o(busy_o), .done_o(done_o)
  );

  // operands frozen at start
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      base_q <= '0; word_q <= '0; pcn_q <= '0; spn_q <= '0; two_q <= 1'b0;
    end else if (load) begin
      base_q <= base_c; word_q <= word_c; pcn_q <= pcn_c; spn_q <= spn_c; two_q <= two_c;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pc_o <= '0; sp_o <= '0;
    end else if (fin) begin
      pc_o <= pcn_q; sp_o <= spn_q;
    end

  assign mem_addr_o  = base_q + ADDR_W'(hi);
  assign mem_wdata_o = hi ? word_q[ADDR_W-1:BYTE_W] : word_q[BYTE_W-1:0];
endmodule

// File: rtl/stk_push_seq_chk.sv
module stk_push_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [BYTE_W-1:0] mem_wdata_o,
  input logic              mem_rdy_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] sp_o
);
  a_r8_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && !mem_rdy_i |=> mem_we_o && $stable(mem_addr_o) && $stable(mem_wdata_o));
  a_r8_no_write_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  a_r3_next_byte_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && $past(mem_we_o && mem_rdy_i) |-> mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1));
  a_r9_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  a_r9_done_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_we_o && mem_rdy_i) && !mem_we_o);
  a_r9_results_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(pc_o) && $stable(sp_o)) |-> done_o);
endmodule

bind stk_push_seq stk_push_seq_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) chk_i (.*);

// File: tb/stk_push_seq_test.sv
module stk_push_seq_test;
  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, mem_rdy_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [2:0]  vec_i = '0;
  logic [15:0] tgt_i = '0, pc_i = '0, sp_i = '0, data_i = '0;
  logic        mem_we_o, busy_o, done_o;
  logic [15:0] mem_addr_o, pc_o, sp_o;
  logic [7:0]  mem_wdata_o;
  int n_chk = 0, n_bad = 0;
  bit fin_run = 0;

  always #5 clk = ~clk;

  stk_push_seq uut (.*, .clk_i(clk));

  typedef struct packed {
    logic [1:0] op; logic [2:0] vec; logic [15:0] tgt, pc, sp, dat;
    logic [1:0] nw; logic [15:0] a0; logic [7:0] d0; logic [15:0] a1; logic [7:0] d1;
    logic [15:0] epc, esp;
  } row_t;

  localparam row_t TBL [9] = '{
    '{2'd0, 3'd0, 16'h1234, 16'h0150, 16'hFFFE, 16'h0000, 2'd2, 16'hFFFC, 8'h50, 16'hFFFD, 8'h01, 16'h1234, 16'hFFFC},
    '{2'd0, 3'd5, 16'h0000, 16'hABCD, 16'h0001, 16'h7777, 2'd2, 16'hFFFF, 8'hCD, 16'h0000, 8'hAB, 16'h0000, 16'hFFFF},
    '{2'd0, 3'd0, 16'hC000, 16'h8001, 16'h0000, 16'h0000, 2'd2, 16'hFFFE, 8'h01, 16'hFFFF, 8'h80, 16'hC000, 16'hFFFE},
    '{2'd1, 3'd7, 16'h9999, 16'h0200, 16'hD000, 16'h0000, 2'd2, 16'hCFFE, 8'h00, 16'hCFFF, 8'h02, 16'h0038, 16'hCFFE},
    '{2'd1, 3'd0, 16'hFFFF, 16'h1FFF, 16'h8000, 16'h0000, 2'd2, 16'h7FFE, 8'hFF, 16'h7FFF, 8'h1F, 16'h0000, 16'h7FFE},
    '{2'd1, 3'd3, 16'h5555, 16'h4321, 16'h0100, 16'h0000, 2'd2, 16'h00FE, 8'h21, 16'h00FF, 8'h43, 16'h0018, 16'h00FE},
    '{2'd2, 3'd0, 16'hF0F0, 16'h0100, 16'h5678, 16'h1234, 2'd2, 16'hF0F0, 8'h34, 16'hF0F1, 8'h12, 16'h0103, 16'h5678},
    '{2'd2, 3'd2, 16'hFFFF, 16'hFFFE, 16'h1111, 16'hBEEF, 2'd2, 16'hFFFF, 8'hEF, 16'h0000, 8'hBE, 16'h0001, 16'h1111},
    '{2'd3, 3'd0, 16'h9000, 16'h0300, 16'h2222, 16'h00A5, 2'd1, 16'h9000, 8'hA5, 16'h0000, 8'h00, 16'h0303, 16'h2222}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] op);
    case (op)
      2'd0: return "R4 call";
      2'd1: return "R5 restart";
      2'd2: return "R6 wide store";
      default: return "R7 narrow store";
    endcase
  endfunction

  task automatic run_row(input row_t v, input int st0, input int st1);
    logic [15:0] ga [2];
    logic [7:0]  gd [2];
    int nw = 0, last = -10, stall = st0;
    bit got = 0;
    @(negedge clk);
    start_i = 1; op_i = v.op; vec_i = v.vec; tgt_i = v.tgt; pc_i = v.pc; sp_i = v.sp; data_i = v.dat;
    mem_rdy_i = 0;
    @(negedge clk);
    start_i = 0; tgt_i = ~v.tgt; pc_i = ~v.pc; sp_i = ~v.sp; data_i = ~v.dat; vec_i = ~v.vec; // R11
    for (int c = 0; c < 40; c++) begin
      if (done_o) begin
        got = 1;
        chk(c == last + 1, "R9 done one cycle after last write", c, last + 1);
        chk(!mem_we_o, "R9 no strobe at done", mem_we_o, 0);
        chk(pc_o == v.epc, tag_of(v.op), pc_o, v.epc);
        chk(sp_o == v.esp, (v.op < 2) ? "R2 sp lowered" : "R6 sp kept", sp_o, v.esp);
        break;
      end
      if (mem_we_o) begin
        if (nw < 2) chk(mem_addr_o == (nw == 0 ? v.a0 : v.a1), "R8 address held", mem_addr_o,
                        nw == 0 ? v.a0 : v.a1);
        if (stall > 0) begin
          mem_rdy_i = 0; stall--;
        end else begin
          mem_rdy_i = 1;
          if (nw < 2) begin ga[nw] = mem_addr_o; gd[nw] = mem_wdata_o; end
          nw++; last = c; stall = st1;
        end
      end else mem_rdy_i = 0;
      @(negedge clk);
    end
    mem_rdy_i = 0;
    chk(got, "R9 done seen", got, 1);
    chk(nw == v.nw, (v.nw == 1) ? "R7 single write" : "R3 two writes", nw, v.nw);
    if (nw >= 1) begin
      chk(ga[0] == v.a0, "R3 first address", ga[0], v.a0);
      chk(gd[0] == v.d0, "R3 low byte first", gd[0], v.d0);
    end
    if (nw == 2 && v.nw == 2) begin
      chk(ga[1] == v.a1, "R3 second address", ga[1], v.a1);
      chk(gd[1] == v.d1, "R3 high byte second", gd[1], v.d1);
    end
    @(negedge clk);
    chk(!busy_o && !done_o, "R9 idle after done", {busy_o, done_o}, 0);
  endtask

  initial begin
    #2_000_000;
    if (!fin_run) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #23;
    chk(!mem_we_o && !busy_o && !done_o, "R1 idle in reset", {mem_we_o, busy_o, done_o}, 0);
    rst_ni = 1;
    @(negedge clk);
    chk(!mem_we_o && !busy_o && !done_o, "R1 idle after reset", {mem_we_o, busy_o, done_o}, 0);
    chk(pc_o == 0 && sp_o == 0, "R1 zero results", {pc_o, sp_o}, 0);

    foreach (TBL[i]) run_row(TBL[i], i % 3, (i % 2) * 2);

    // R8: long stall on both writes
    run_row(TBL[6], 5, 4);

    // R10: start while busy is ignored
    begin
      int wr = 0, dn = 0;
      @(negedge clk);
      start_i = 1; op_i = 2'd0; tgt_i = 16'h2468; pc_i = 16'h1357; sp_i = 16'h4000; mem_rdy_i = 0;
      @(negedge clk);
      op_i = 2'd3; tgt_i = 16'h0F00; data_i = 16'h00EE; // still pulsing start
      for (int c = 0; c < 10; c++) begin
        if (c == 1) start_i = 0;
        if (c == 3) start_i = 1; // during done-cycle region
        if (c == 4) start_i = 0;
        mem_rdy_i = mem_we_o && (c != 0);
        if (mem_we_o && mem_rdy_i) begin
          wr++;
          chk(mem_addr_o != 16'h0F00, "R10 no foreign write", mem_addr_o, 16'h3FFE);
        end
        if (done_o) dn++;
        @(negedge clk);
        if (c == 4 && busy_o == 1'b0) ;
      end
      mem_rdy_i = 0;
      chk(wr == 2, "R10 only call writes", wr, 2);
      chk(dn == 1, "R10 single done", dn, 1);
      chk(pc_o == 16'h2468, "R10 result kept", pc_o, 16'h2468);
      chk(!busy_o, "R10 idle", busy_o, 0);
    end

    fin_run = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule